// File: doc/BRIEF.md
# Overlapping 1001 Serial Pattern Detector

This block watches a one-bit serial stream, taking one new bit on every rising clock edge, and raises a flag each time the four most recent bits read 1, 0, 0, 1 with the oldest bit first. Matches may overlap, so the closing 1 of one match can start the next one. The input must already be synchronous to the clock.

Two independent recognisers run side by side on the same stream. The first is a five-state machine whose flag depends only on its state. That flag rises after the clock edge that takes in the closing 1. The second is a four-state machine whose flag depends on its state and on the present input bit. That flag is high while the closing 1 is still waiting at the input. Placing both in one block shows that the state-driven flag trails the input-driven flag by exactly one cycle for every match.

Top module: `serial_match_pair`

## Requirements
- R1: While `rst` is high, both `moore_hit` and `mealy_hit` are low. A clock edge with `rst` high returns both recognisers to their start state, so bits taken in before that edge cannot count toward a later match.
- R2: `moore_hit` is high in a cycle exactly when the last four bits taken in since reset are 1, 0, 0, 1, with the oldest bit first.
- R3: `mealy_hit` is high exactly when the last three bits taken in since reset are 1, 0, 0, with the oldest bit first, and the present `din` is 1.
- R4: Overlapping matches are reported. For the stream 1001001, `mealy_hit` is high while the 4th bit and the 7th bit are presented. `moore_hit` is high in the cycles after the 4th bit and after the 7th bit are taken in. Both flags are low in every other cycle of that stream.
- R5: `moore_hit` changes only at a rising clock edge. Toggling `din` between edges leaves it unchanged.
- R6: Outside reset, `moore_hit` in a cycle equals the value `mealy_hit` had at the end of the previous cycle.
- R7: A reset pulse in the middle of a partial match (for example after 1, 0, 0) cancels it. A following 1 then raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| din | input | 1 | Serial data bit, taken in on each rising edge. |
| moore_hit | output | 1 | Match flag that depends only on the state. Trails the input-driven flag by one cycle. |
| mealy_hit | output | 1 | Match flag that depends on the state and the present `din`. |

## Verification
Two functions can fall in the same cycle: the end of one match and the start of the next. The closing 1 of a match is also the first 1 of a new match, so the recogniser must report one match and begin tracking the next on the same edge. This is provoked with the stream 1001001 and with long 1001 runs inside pseudo-random traffic. In every cycle, the flags are judged against a behavioural history of the bits taken in since reset. Within each cycle, `din` is also toggled between edges to show that the state-driven flag does not move, while the input-driven flag follows the bit that is finally presented.

// File: rtl/match_pkg.sv
package match_pkg;
  localparam int MOORE_W = 3;
  localparam int MEALY_W = 2;

  typedef enum logic [MOORE_W-1:0] {
    MO_IDLE = 3'd0,
    MO_A    = 3'd1,
    MO_AB   = 3'd2,
    MO_ABB  = 3'd3,
    MO_HIT  = 3'd4
  } moore_st_e;

  typedef enum logic [MEALY_W-1:0] {
    ME_IDLE = 2'd0,
    ME_A    = 2'd1,
    ME_AB   = 2'd2,
    ME_ABB  = 2'd3
  } mealy_st_e;
endpackage

// File: rtl/moore_track.sv
module moore_track
  import match_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  moore_st_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      MO_IDLE: st_d = din ? MO_A : MO_IDLE;
      MO_A:    st_d = din ? MO_A : MO_AB;
      MO_AB:   st_d = din ? MO_A : MO_ABB;
      MO_ABB:  st_d = din ? MO_HIT : MO_IDLE;
      MO_HIT:  st_d = din ? MO_A : MO_AB;   // closing 1 may open a new match
      default: st_d = MO_IDLE;              // unreachable codes recover
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= MO_IDLE;
    else     st_q <= st_d;
  end

  assign hit = (st_q == MO_HIT) & ~rst;

  // R2: a hit follows a consumed 1
  a_r2_hit_after_one: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(din));
  // R4: leaving the match state keeps the overlap
  a_r4_overlap_exit: assert property (@(posedge clk) disable iff (rst)
    (st_q == MO_HIT) |=> (st_q == MO_A || st_q == MO_AB));
endmodule

// File: rtl/mealy_track.sv
module mealy_track
  import match_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  mealy_st_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      ME_IDLE: st_d = din ? ME_A : ME_IDLE;
      ME_A:    st_d = din ? ME_A : ME_AB;
      ME_AB:   st_d = din ? ME_A : ME_ABB;
      ME_ABB:  st_d = din ? ME_A : ME_IDLE;
      default: st_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ME_IDLE;
    else     st_q <= st_d;
  end

  assign hit = (st_q == ME_ABB) & din & ~rst;

  // R3: the input-driven flag needs a present 1
  a_r3_needs_one: assert property (@(posedge clk) disable iff (rst)
    hit |-> din);
endmodule

// File: rtl/serial_match_pair.sv
module serial_match_pair (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic moore_hit,
  output logic mealy_hit
);
  moore_track u_moore (.clk(clk), .rst(rst), .din(din), .hit(moore_hit));
  mealy_track u_mealy (.clk(clk), .rst(rst), .din(din), .hit(mealy_hit));

  // R1: flags stay quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> (!moore_hit && !mealy_hit));
  // R6: state-driven flag trails the input-driven one by a cycle
  a_r6_one_cycle_lag: assert property (@(posedge clk) disable iff (rst)
    moore_hit == $past(mealy_hit));
endmodule

// File: tb/tb_serial_match_pair.sv
module tb_serial_match_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic moore_hit, mealy_hit;

  int n_chk = 0;
  int n_fail = 0;
  int hist = 0;
  int nbits = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  serial_match_pair dut (.clk(clk), .rst(rst), .din(din),
                         .moore_hit(moore_hit), .mealy_hit(mealy_hit));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic exp_moore();
    return !rst && nbits >= 4 && (hist & 15) == 9;
  endfunction

  function automatic logic exp_mealy(input logic b);
    return !rst && nbits >= 3 && (hist & 7) == 4 && b;
  endfunction

  // one cycle: present b, compare both flags, toggle between edges, consume
  task automatic step(input logic b, input string req);
    logic m0;
    @(negedge clk);
    din = b;
    #1;
    check({req, "/R2"}, moore_hit, exp_moore());
    check({req, "/R3"}, mealy_hit, exp_mealy(b));
    m0 = moore_hit;
    din = ~b;
    #1;
    check("R5", moore_hit, m0);
    din = b;
    #1;
    check({req, "/R3"}, mealy_hit, exp_mealy(b));
    @(posedge clk);
    if (rst) begin nbits = 0; hist = 0; end
    else begin hist = ((hist << 1) | int'(b)) & 15; nbits++; end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: flags low while reset held, even with a 1 presented
    step(1'b1, "R1");
    step(1'b0, "R1");
    @(negedge clk); din = 1'b1; #1;
    check("R1", moore_hit, 1'b0);
    check("R1", mealy_hit, 1'b0);
    @(posedge clk);
    rst = 1'b0; nbits = 0; hist = 0;

    // R4: overlapping stream 1001001
    begin
      logic [6:0] s = 7'b1001001;
      for (int i = 6; i >= 0; i--) begin
        @(negedge clk); din = s[i]; #1;
        check("R4", mealy_hit, (i == 3 || i == 0));
        check("R4", moore_hit, (i == 2));
        @(posedge clk);
        hist = ((hist << 1) | int'(s[i])) & 15; nbits++;
      end
      @(negedge clk); din = 1'b0; #1;
      check("R4", moore_hit, 1'b1);
      check("R4", mealy_hit, 1'b0);
      @(posedge clk);
      hist = (hist << 1) & 15; nbits++;
    end

    // R7: reset in mid partial match cancels it
    step(1'b1, "R7"); step(1'b0, "R7"); step(1'b0, "R7");
    rst = 1'b1;
    step(1'b1, "R7");
    rst = 1'b0;
    step(1'b1, "R7");
    step(1'b0, "R7");

    // R2/R3/R6: pseudo-random traffic, biased toward zeros
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & (lfsr[3] | lfsr[5]), "R6");
    end
    // repeated overlap runs
    for (int k = 0; k < 6; k++) begin
      step(1'b1, "R4"); step(1'b0, "R4"); step(1'b0, "R4");
    end
    step(1'b1, "R4");
    step(1'b0, "R4");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule